// File: doc/BRIEF.md
# Serial ADC Frame Capture Master

This block drives a three-wire serial sampling converter. It divides the system clock down to a serial clock and issues a positive convert pulse at the start of every frame. It then shifts the converter's data line into a parallel sample on the falling serial-clock edges. Each finished sample is stored right-justified and zero-filled in a 16-bit word.

Samples go out through a buffer write port into a memory that is split into two equal halves. Writing alternates between the halves without a pause, so a consumer can drain one half while the other fills. When the last entry of a half is written, a one-cycle ready pulse is raised together with the index of that half. Dropping the enable lets the frame in progress finish, and then the converter pins go quiet.

Top module: `adc_frame_capture`

## Requirements
- R1: The serial clock `sck_o` has a period of 2*CLK_DIV system cycles with equal high and low time, and it changes only on divider ticks. Its first rising edge in a frame comes CLK_DIV cycles after `conv_o` rises.
- R2: `conv_o` is a positive pulse that rises while `sck_o` is low and stays high for exactly 2*CLK_DIV system cycles. Each pulse is followed by exactly FRAME_CLKS (16) rising edges of `sck_o`, and while enabled the next pulse follows with no gap.
- R3: `sdo_i` is sampled only at the system edge where `sck_o` goes from high to low.
- R4: Within a frame, number the rising `sck_o` edges 1 to FRAME_CLKS. The sample bits are taken on the falling edges after rising edges FIRST_EDGE (3) through FIRST_EDGE+DATA_BITS-1, most significant bit first. `sdo_i` on every other falling edge is ignored.
- R5: The stored word `wr_data_o` holds the sample in bits DATA_BITS-1:0, and all bits above it are zero.
- R6: Each frame produces one single-cycle write. It is asserted in the system cycle after the falling edge that follows rising edge FRAME_CLKS. Addresses start at 0 after reset, rise by one per write and wrap at 2*HALF_DEPTH. The address MSB is the half index.
- R7: `half_rdy_o` pulses for one cycle together with the write to the last entry of a half (all lower address bits one). `half_idx_o` then equals that write's address MSB.
- R8: When `enable` falls, the current frame still completes, including its write. After that `sck_o` and `conv_o` stay low and no writes occur. Raising `enable` again resumes at the next address.
- R9: While `rst` is high, `conv_o`, `sck_o`, `wr_en_o` and `half_rdy_o` are low, and the write pointer returns to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run frames while high |
| conv_o | output | 1 | Convert-start strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Serial data from the converter |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | ADDR_W | Buffer write address, MSB selects the half |
| wr_data_o | output | 16 | Right-justified, zero-filled sample word |
| half_rdy_o | output | 1 | One-cycle pulse when a half is complete |
| half_idx_o | output | 1 | Index of the half just completed |

## Verification
The assertions take for granted that `rst` is held for at least one clock before use. They also rely on the sequencer never requesting writes in consecutive cycles, which is true for any CLK_DIV of at least one. The converter model in the bench drives `sdo_i` only just after a rising `sck_o` edge, so the data is stable at the following falling edge. It drives ones outside the bit window, so ignored positions and zero-filled upper bits are visible at the write port. Enable and reset are changed away from the convert pulse, so the pulse-width checks see whole pulses.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned SAMPLE_WORD_W = 16;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || tick_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_cap_pkg::*;
#(
  parameter int FRAME_CLKS = 16,
  parameter int FIRST_EDGE = 3,
  parameter int DATA_BITS  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick_i,
  output logic conv_o,
  output logic sck_o,
  output logic sample_o,
  output logic frame_end_o
);
  localparam int SLOTS = 2 * FRAME_CLKS;
  localparam int SW = $clog2(SLOTS);
  localparam int LAST_EDGE = FIRST_EDGE + DATA_BITS - 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] K_LO = SW'(FIRST_EDGE);
  localparam logic [SW-1:0] K_HI = SW'(LAST_EDGE);

  seq_state_e    state_q;
  logic [SW-1:0] slot_q;
  logic [SW:0]   slot_inc;
  logic [SW-1:0] edge_k;
  logic          at_last;
  logic          falling;
  logic          conv_q, sck_q, end_q;

  always_comb begin
    slot_inc = {1'b0, slot_q} + 1'b1;
    edge_k   = slot_inc[SW:1];
    at_last  = (slot_q == SLOT_LAST);
    falling  = tick_i && (state_q == SEQ_RUN) && slot_q[0];
    sample_o = falling && (edge_k >= K_LO) && (edge_k <= K_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      conv_q  <= 1'b0;
      sck_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      end_q <= tick_i && (state_q == SEQ_RUN) && at_last;
      if (tick_i) begin
        case (state_q)
          SEQ_IDLE: begin
            if (enable) begin
              state_q <= SEQ_RUN;
              slot_q  <= '0;
              conv_q  <= 1'b1;
              sck_q   <= 1'b0;
            end
          end
          default: begin
            if (at_last) begin
              sck_q <= 1'b0;
              if (enable) begin
                slot_q <= '0;
                conv_q <= 1'b1;
              end else begin
                state_q <= SEQ_IDLE;
                conv_q  <= 1'b0;
              end
            end else begin
              slot_q <= slot_inc[SW-1:0];
              sck_q  <= slot_inc[0];
              conv_q <= (slot_inc < (SW+1)'(2));
            end
          end
        endcase
      end
    end
  end

  assign conv_o      = conv_q;
  assign sck_o       = sck_q;
  assign frame_end_o = end_q;

  // R2
  conv_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_q) |-> !sck_q);

  // R2
  conv_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_q) |-> !sck_q);
endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int DATA_BITS = 14,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              sdo_i,
  output logic [WORD_W-1:0] word_o
);
  logic [DATA_BITS-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst)           shift_q <= '0;
    else if (sample_i) shift_q <= {shift_q[DATA_BITS-2:0], sdo_i};
  end

  assign word_o = WORD_W'(shift_q);
endmodule

// File: rtl/adc_pingpong_wr.sv
module adc_pingpong_wr #(
  parameter int HALF_DEPTH = 512,
  parameter int WORD_W     = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            push_i,
  input  logic [WORD_W-1:0]               data_i,
  output logic                            wr_en_o,
  output logic [$clog2(HALF_DEPTH):0]     wr_addr_o,
  output logic [WORD_W-1:0]               wr_data_o,
  output logic                            half_rdy_o,
  output logic                            half_idx_o
);
  localparam int HALF_AW = $clog2(HALF_DEPTH);
  localparam int ADDR_W  = HALF_AW + 1;

  logic [ADDR_W-1:0] ptr_q;
  logic              half_last;

  assign half_last = &ptr_q[HALF_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      half_rdy_o <= 1'b0;
      half_idx_o <= 1'b0;
    end else begin
      wr_en_o    <= push_i;
      half_rdy_o <= push_i && half_last;
      if (push_i) begin
        wr_addr_o  <= ptr_q;
        wr_data_o  <= data_i;
        half_idx_o <= ptr_q[HALF_AW];
        ptr_q      <= ptr_q + 1'b1;
      end
    end
  end

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  // R7
  half_rdy_last_chk: assert property (@(posedge clk) disable iff (rst)
    half_rdy_o |-> (wr_en_o && (&wr_addr_o[HALF_AW-1:0]) && (half_idx_o == wr_addr_o[HALF_AW])));
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture
  import adc_cap_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_CLKS = 16,
  parameter int FIRST_EDGE = 3,
  parameter int DATA_BITS  = 14,
  parameter int HALF_DEPTH = 512,
  localparam int ADDR_W    = $clog2(HALF_DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  output logic                     conv_o,
  output logic                     sck_o,
  input  logic                     sdo_i,
  output logic                     wr_en_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [SAMPLE_WORD_W-1:0] wr_data_o,
  output logic                     half_rdy_o,
  output logic                     half_idx_o
);
  logic                     tick;
  logic                     sample_stb;
  logic                     frame_end;
  logic [SAMPLE_WORD_W-1:0] word;

  adc_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  adc_frame_seq #(
    .FRAME_CLKS(FRAME_CLKS), .FIRST_EDGE(FIRST_EDGE), .DATA_BITS(DATA_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .tick_i(tick),
    .conv_o(conv_o), .sck_o(sck_o), .sample_o(sample_stb), .frame_end_o(frame_end)
  );

  adc_shift_rx #(.DATA_BITS(DATA_BITS), .WORD_W(SAMPLE_WORD_W)) u_rx (
    .clk(clk), .rst(rst), .sample_i(sample_stb), .sdo_i(sdo_i), .word_o(word)
  );

  adc_pingpong_wr #(.HALF_DEPTH(HALF_DEPTH), .WORD_W(SAMPLE_WORD_W)) u_wr (
    .clk(clk), .rst(rst), .push_i(frame_end), .data_i(word),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .half_rdy_o(half_rdy_o), .half_idx_o(half_idx_o)
  );

  // R3
  sample_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> $fell(sck_o));

  // R1
  sck_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sck_o));

  // R6
  write_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> wr_en_o);
endmodule

// File: tb/tb_adc_frame_capture.sv
module tb_adc_frame_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int FRM   = 16;
  localparam int FIRST = 3;
  localparam int DB    = 14;
  localparam int HALF  = 4;
  localparam int AW    = $clog2(HALF) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          sdo_i;
  logic          conv_o, sck_o, wr_en_o, half_rdy_o, half_idx_o;
  logic [AW-1:0] wr_addr_o;
  logic [15:0]   wr_data_o;

  int checks = 0;
  int fails  = 0;
  logic [AW+15:0] exp_q[$];
  int exp_addr = 0;
  int wr_count = 0;

  adc_frame_capture #(
    .CLK_DIV(DIV), .FRAME_CLKS(FRM), .FIRST_EDGE(FIRST), .DATA_BITS(DB), .HALF_DEPTH(HALF)
  ) dut (
    .clk(clk), .rst(rst), .enable(enable), .conv_o(conv_o), .sck_o(sck_o),
    .sdo_i(sdo_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .half_rdy_o(half_rdy_o), .half_idx_o(half_idx_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DB-1:0] pattern(input int n);
    case (n)
      0: return 14'h3FFF;
      1: return 14'h0000;
      2: return 14'h2AAA;
      3: return 14'h1555;
      4: return 14'h2001;
      default: return DB'((n * 2749) ^ 14'h0A5C);
    endcase
  endfunction

  // Converter model and scoreboard driver: one expected item per convert pulse
  initial begin
    int k;
    int fno;
    logic [DB-1:0] cur;
    k = 0; fno = 0; cur = '0;
    sdo_i = 1'b1;
    forever begin
      @(posedge sck_o);
      if (conv_o) begin
        k = 1;
        cur = pattern(fno);
        exp_q.push_back({AW'(exp_addr), 16'(cur)});
        exp_addr = (exp_addr + 1) % (2 * HALF);
        fno++;
      end else begin
        k++;
      end
      #1;
      if (k >= FIRST && k < FIRST + DB) sdo_i = cur[DB-1-(k-FIRST)];
      else                              sdo_i = 1'b1;
    end
  end

  // Monitor
  int cyc = 0;
  logic sck_d1 = 1'b0, sck_d2 = 1'b0, conv_d1 = 1'b0;
  int conv_len = 0;
  int rises_in_frame = -1;
  int last_rise = 0;
  int conv_rise_cyc = 0;

  initial begin
    logic [AW+15:0] item;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        rises_in_frame = -1;
        conv_len = 0;
        sck_d1 = 1'b0; sck_d2 = 1'b0; conv_d1 = 1'b0;
        continue;
      end
      if (conv_o && !conv_d1) begin
        // R2: rise while clock is low, previous frame had 16 rising edges
        check(sck_o == 1'b0, "R2 conv rises with sck low", 32'(sck_o), 0);
        if (rises_in_frame >= 0)
          check(rises_in_frame == FRM, "R2 rising edges per frame", rises_in_frame, FRM);
        rises_in_frame = 0;
        conv_rise_cyc = cyc;
      end
      if (conv_o) conv_len++;
      if (!conv_o && conv_d1) begin
        check(conv_len == 2 * DIV, "R2 conv width", conv_len, 2 * DIV);
        conv_len = 0;
      end
      if (sck_o && !sck_d1 && rises_in_frame >= 0) begin
        if (rises_in_frame == 0)
          check(cyc - conv_rise_cyc == DIV, "R1 first rise delay", cyc - conv_rise_cyc, DIV);
        else
          check(cyc - last_rise == 2 * DIV, "R1 sck period", cyc - last_rise, 2 * DIV);
        rises_in_frame++;
        last_rise = cyc;
      end
      if (wr_en_o) begin
        wr_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected write", 32'(wr_addr_o), 0);
        end else begin
          item = exp_q.pop_front();
          check(wr_addr_o == item[AW+15:16], "R6 write address", 32'(wr_addr_o), 32'(item[AW+15:16]));
          check(wr_data_o == item[15:0], "R4 sample value", 32'(wr_data_o), 32'(item[15:0]));
          check(wr_data_o[15:DB] == '0, "R5 upper bits zero", 32'(wr_data_o[15:DB]), 0);
          check(sck_d2 && !sck_d1 && !sck_o, "R6 write one cycle after final fall",
                {29'd0, sck_d2, sck_d1, sck_o}, 32'b100);
          check(half_rdy_o == (&item[AW+14:16]), "R7 half ready pulse",
                32'(half_rdy_o), 32'(&item[AW+14:16]));
          if (half_rdy_o)
            check(half_idx_o == item[AW+15], "R7 half index", 32'(half_idx_o), 32'(item[AW+15]));
        end
      end else if (half_rdy_o) begin
        check(1'b0, "R7 half ready without write", 1, 0);
      end
      sck_d2 = sck_d1;
      sck_d1 = sck_o;
      conv_d1 = conv_o;
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 60000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int snap_wr;
    bit quiet;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(!conv_o && !sck_o && !wr_en_o && !half_rdy_o, "R9 outputs low in reset",
          {28'd0, conv_o, sck_o, wr_en_o, half_rdy_o}, 0);
    rst = 1'b0;
    enable = 1'b1;
    wait (wr_count == 10);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    // R8: frame in flight completes, then the pins stay quiet
    wait (wr_count == 11);
    repeat (5) @(negedge clk);
    snap_wr = wr_count;
    quiet = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (conv_o || sck_o) quiet = 1'b0;
    end
    check(quiet, "R8 idle with pins low", 32'(!quiet), 0);
    check(wr_count == snap_wr, "R8 no writes while disabled", wr_count, snap_wr);
    check(exp_q.size() == 0, "R8 frame finished before idle", exp_q.size(), 0);
    enable = 1'b1;
    wait (wr_count == 19);
    repeat (20) @(negedge clk);
    // R9: reset mid-run returns the pointer to zero
    rst = 1'b1;
    exp_q.delete();
    exp_addr = 0;
    repeat (3) @(negedge clk);
    check(!conv_o && !sck_o && !wr_en_o && !half_rdy_o, "R9 outputs low in mid-run reset",
          {28'd0, conv_o, sck_o, wr_en_o, half_rdy_o}, 0);
    rst = 1'b0;
    wait (wr_count == 25);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    wait (wr_count == 26);
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R6 every frame written", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule